// File: doc/BRIEF.md
# Packet classifier and banked store

This block accepts a stream of 32-bit packet words framed by start and end markers, and routes each packet by a tag word. The tag is the first payload word, at a fixed word index `HDR_WORDS` after the start of the packet. A tag of zero selects a program packet. Its payload, minus the tag itself, is written into one of two program banks. A tag of one selects a data packet, which is written whole, headers and trailer included, into one of four data banks. Any other tag sends the packet unchanged to a pass-through output.

Incoming words run through a fixed-length delay line. The tag is therefore already classified when the first word of the packet reaches the store stage. Each bank class has a rotating pointer and a set of per-bank full flags. A packet claims the bank under the pointer only if that bank is empty, and the claim is sealed at the packet's last word. The consumer frees a bank with a one-cycle release pulse. Memory writes leave the block as registered write ports, so the memories and their read sides sit outside it.

Packets are expected to arrive with `in_valid` held high from the first word to the last. Each packet must be at least `HDR_WORDS+1` words long.

Top module: `pkt_classify_store`

## Requirements
- R1: A packet whose word at index HDR_WORDS (counting from 0 at the start word) equals 0x00000000 writes its words at indices HDR_WORDS+1 onward to program offsets 0, 1, 2 … of the selected program bank (`pm_addr` = {bank, offset}). Neither its header words nor its tag word are written, and no data write occurs.
- R2: A packet whose tag word equals 0x00000001 writes every word, index 0 onward, to data offset equal to its index in the selected data bank (`dm_addr` = {bank, offset}). No program write occurs.
- R3: A packet with any other tag is written to no memory. All of its words appear on the pass-through output in order, with `pass_sop` on the first word and `pass_eop` on the last.
- R4: The type decision is taken from the tag word alone. Every word reaches the registered outputs exactly HDR_WORDS+1 clock edges after the edge that samples it at the input.
- R5: Data packets fill banks 0,1,2,3 in turn and program packets fill banks 0,1 in turn, wrapping around. The bank's bit in `data_full` or `prog_full` is set once the packet's last word is stored.
- R6: If the bank under the pointer is full, the packet is dropped. It causes no write, the pointer does not move, and `drop_cnt` increases by one (saturating).
- R7: A one-cycle pulse on a bit of `data_free` or `prog_free` clears that bank's full flag, and the bank can then be filled again. A full flag never clears without such a pulse.
- R8: Words beyond the bank depth are not written. A data packet stores at most DATA_DEPTH words, and a program packet at most PROG_DEPTH payload words.
- R9: `wr_grant` is high exactly on the output cycles that carry a word of a data packet being stored, including words cut off by R8. It is low otherwise, and it covers every data write.
- R10: Reset clears all full flags, both pointers (back to bank 0), `drop_cnt`, and all write-enable, grant and pass-valid outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_sop | input | 1 | First word of a packet |
| in_eop | input | 1 | Last word of a packet |
| in_data | input | DW | Input word |
| prog_free | input | PROG_BANKS | Release pulse per program bank |
| data_free | input | DATA_BANKS | Release pulse per data bank |
| pm_we | output | 1 | Program memory write enable |
| pm_addr | output | log2(PROG_BANKS)+log2(PROG_DEPTH) | Program memory address {bank, offset} |
| pm_wdata | output | DW | Program memory write data |
| dm_we | output | 1 | Data memory write enable |
| dm_addr | output | log2(DATA_BANKS)+log2(DATA_DEPTH) | Data memory address {bank, offset} |
| dm_wdata | output | DW | Data memory write data |
| wr_grant | output | 1 | High while a data packet is being written |
| prog_full | output | PROG_BANKS | Program bank holds a program |
| data_full | output | DATA_BANKS | Data bank holds a packet |
| pass_valid | output | 1 | Pass-through word valid |
| pass_sop | output | 1 | Pass-through first word |
| pass_eop | output | 1 | Pass-through last word |
| pass_data | output | DW | Pass-through word |
| drop_cnt | output | CNT_W | Saturating count of dropped packets |

## Verification
The three tag classes are sent back to back with different lengths. Because each word carries its packet number and index, a shifted offset, a written tag word or a swapped destination shows up as a content mismatch. Data packets are sent until every bank is full, and a further one must be dropped. The same is done for program packets, which separates the pointer-rotation and full-flag logic from plain routing. A data packet longer than the bank and a program payload longer than the bank show whether the truncation and the grant window are kept apart. A release followed by a new packet, and a reset in the middle of the run, show that the pointers and flags restart as required.

// File: rtl/pktcls_pkg.sv
package pktcls_pkg;

  typedef enum logic [1:0] {
    CLS_PROG  = 2'd0,
    CLS_DATA  = 2'd1,
    CLS_OTHER = 2'd2
  } pkt_cls_e;

  typedef enum logic [2:0] {
    SM_IDLE = 3'd0,
    SM_PROG = 3'd1,
    SM_DATA = 3'd2,
    SM_PASS = 3'd3,
    SM_DROP = 3'd4
  } store_mode_e;

  typedef struct packed {
    logic vld;
    logic sop;
    logic eop;
  } beat_ctl_t;

endpackage

// File: rtl/pkt_delay_line.sv
module pkt_delay_line #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  pktcls_pkg::beat_ctl_t ctl_i,
  input  logic [DW-1:0]         data_i,
  output pktcls_pkg::beat_ctl_t ctl_o,
  output logic [DW-1:0]         data_o
);
  import pktcls_pkg::*;

  beat_ctl_t     ctl_q [DEPTH];
  logic [DW-1:0] dat_q [DEPTH];

  // payload shift: no reset so it maps to shift-register primitives
  always_ff @(posedge clk) begin
    dat_q[0] <= data_i;
    for (int s = 1; s < DEPTH; s++) dat_q[s] <= dat_q[s-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < DEPTH; s++) ctl_q[s] <= '0;
    end else begin
      ctl_q[0] <= ctl_i;
      for (int s = 1; s < DEPTH; s++) ctl_q[s] <= ctl_q[s-1];
    end
  end

  assign ctl_o  = ctl_q[DEPTH-1];
  assign data_o = dat_q[DEPTH-1];

endmodule

// File: rtl/pkt_tag_classifier.sv
module pkt_tag_classifier #(
  parameter int            DW        = 32,
  parameter int            HDR_WORDS = 3,
  parameter logic [DW-1:0] TAG_PROG  = '0,
  parameter logic [DW-1:0] TAG_DATA  = DW'(1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  vld,
  input  logic                  sop,
  input  logic [DW-1:0]         data,
  output pktcls_pkg::pkt_cls_e  cls
);
  import pktcls_pkg::*;

  localparam int            IW    = $clog2(HDR_WORDS + 2) + 1;
  localparam logic [IW-1:0] TAG_I = IW'(HDR_WORDS);
  localparam logic [IW-1:0] SAT_I = IW'(HDR_WORDS + 1);

  logic [IW-1:0] idx_q, idx_now;

  assign idx_now = sop ? '0 : idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      cls   <= CLS_OTHER;
    end else if (vld) begin
      idx_q <= (idx_now == SAT_I) ? idx_now : idx_now + 1'b1;
      if (idx_now == TAG_I) begin
        if (data == TAG_PROG)      cls <= CLS_PROG;
        else if (data == TAG_DATA) cls <= CLS_DATA;
        else                       cls <= CLS_OTHER;
      end
    end
  end

endmodule

// File: rtl/bank_ring.sv
module bank_ring #(
  parameter int NB = 4,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          commit,
  input  logic [NB-1:0] release_i,
  output logic [BW-1:0] ptr,
  output logic          avail,
  output logic [NB-1:0] full
);
  localparam logic [BW-1:0] LAST = BW'(NB - 1);

  logic [NB-1:0] seal;

  assign seal  = commit ? (NB'(1) << ptr) : '0;
  assign avail = !full[ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= '0;
      full <= '0;
    end else begin
      full <= (full & ~release_i) | seal;
      if (commit) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

endmodule

// File: rtl/pkt_classify_store.sv
module pkt_classify_store #(
  parameter int DW         = 32,
  parameter int HDR_WORDS  = 3,
  parameter int PROG_BANKS = 2,
  parameter int PROG_DEPTH = 16,
  parameter int DATA_BANKS = 4,
  parameter int DATA_DEPTH = 16,
  parameter int CNT_W      = 8,
  localparam int PBW = (PROG_BANKS > 1) ? $clog2(PROG_BANKS) : 1,
  localparam int POW = (PROG_DEPTH > 1) ? $clog2(PROG_DEPTH) : 1,
  localparam int DBW = (DATA_BANKS > 1) ? $clog2(DATA_BANKS) : 1,
  localparam int DOW = (DATA_DEPTH > 1) ? $clog2(DATA_DEPTH) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic                  in_sop,
  input  logic                  in_eop,
  input  logic [DW-1:0]         in_data,
  input  logic [PROG_BANKS-1:0] prog_free,
  input  logic [DATA_BANKS-1:0] data_free,
  output logic                  pm_we,
  output logic [PBW+POW-1:0]    pm_addr,
  output logic [DW-1:0]         pm_wdata,
  output logic                  dm_we,
  output logic [DBW+DOW-1:0]    dm_addr,
  output logic [DW-1:0]         dm_wdata,
  output logic                  wr_grant,
  output logic [PROG_BANKS-1:0] prog_full,
  output logic [DATA_BANKS-1:0] data_full,
  output logic                  pass_valid,
  output logic                  pass_sop,
  output logic                  pass_eop,
  output logic [DW-1:0]         pass_data,
  output logic [CNT_W-1:0]      drop_cnt
);
  import pktcls_pkg::*;

  localparam int            DLY   = HDR_WORDS + 1;
  localparam int            IW    = $clog2(PROG_DEPTH + DATA_DEPTH + HDR_WORDS + 2) + 1;
  localparam logic [IW-1:0] HDR_I = IW'(HDR_WORDS);
  localparam logic [IW-1:0] PD_I  = IW'(PROG_DEPTH);
  localparam logic [IW-1:0] DD_I  = IW'(DATA_DEPTH);

  // input framing and delay line
  beat_ctl_t     in_ctl, d_ctl;
  logic [DW-1:0] d_data;
  pkt_cls_e      cls;

  assign in_ctl = '{vld: in_valid, sop: in_sop, eop: in_eop};

  pkt_delay_line #(.DW(DW), .DEPTH(DLY)) u_dly (
    .clk(clk), .rst(rst), .ctl_i(in_ctl), .data_i(in_data),
    .ctl_o(d_ctl), .data_o(d_data)
  );

  pkt_tag_classifier #(.DW(DW), .HDR_WORDS(HDR_WORDS)) u_cls (
    .clk(clk), .rst(rst), .vld(in_valid), .sop(in_sop), .data(in_data),
    .cls(cls)
  );

  // bank bookkeeping for both memory classes
  logic           p_commit, d_commit, p_avail, d_avail;
  logic [PBW-1:0] p_ptr;
  logic [DBW-1:0] d_ptr;

  bank_ring #(.NB(PROG_BANKS)) u_pring (
    .clk(clk), .rst(rst), .commit(p_commit), .release_i(prog_free),
    .ptr(p_ptr), .avail(p_avail), .full(prog_full)
  );

  bank_ring #(.NB(DATA_BANKS)) u_dring (
    .clk(clk), .rst(rst), .commit(d_commit), .release_i(data_free),
    .ptr(d_ptr), .avail(d_avail), .full(data_full)
  );

  // store stage
  store_mode_e   mode_q, mode_now, start_mode;
  logic [IW-1:0] idx_q, idx_now, off_p;
  logic          prog_hit, data_hit, drop_inc;

  always_comb begin
    case (cls)
      CLS_PROG: start_mode = p_avail ? SM_PROG : SM_DROP;
      CLS_DATA: start_mode = d_avail ? SM_DATA : SM_DROP;
      default:  start_mode = SM_PASS;
    endcase
    mode_now = d_ctl.sop ? start_mode : mode_q;
    idx_now  = d_ctl.sop ? '0 : idx_q;
    off_p    = idx_now - HDR_I - 1'b1;
    prog_hit = d_ctl.vld && (mode_now == SM_PROG) && (idx_now > HDR_I) && (off_p < PD_I);
    data_hit = d_ctl.vld && (mode_now == SM_DATA) && (idx_now < DD_I);
    drop_inc = d_ctl.vld && d_ctl.sop && (start_mode == SM_DROP);
    p_commit = d_ctl.vld && d_ctl.eop && (mode_now == SM_PROG);
    d_commit = d_ctl.vld && d_ctl.eop && (mode_now == SM_DATA);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= SM_IDLE;
      idx_q  <= '0;
    end else if (d_ctl.vld) begin
      mode_q <= d_ctl.eop ? SM_IDLE : mode_now;
      idx_q  <= (idx_now == '1) ? idx_now : idx_now + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pm_we      <= 1'b0;
      dm_we      <= 1'b0;
      wr_grant   <= 1'b0;
      pass_valid <= 1'b0;
      pass_sop   <= 1'b0;
      pass_eop   <= 1'b0;
      drop_cnt   <= '0;
    end else begin
      pm_we      <= prog_hit;
      dm_we      <= data_hit;
      wr_grant   <= d_ctl.vld && (mode_now == SM_DATA);
      pass_valid <= d_ctl.vld && (mode_now == SM_PASS);
      pass_sop   <= d_ctl.vld && (mode_now == SM_PASS) && d_ctl.sop;
      pass_eop   <= d_ctl.vld && (mode_now == SM_PASS) && d_ctl.eop;
      if (drop_inc && (drop_cnt != '1)) drop_cnt <= drop_cnt + 1'b1;
    end
  end

  // address and data lanes carry no reset
  always_ff @(posedge clk) begin
    pm_addr   <= {p_ptr, off_p[POW-1:0]};
    pm_wdata  <= d_data;
    dm_addr   <= {d_ptr, idx_now[DOW-1:0]};
    dm_wdata  <= d_data;
    pass_data <= d_data;
  end

endmodule

// File: rtl/pkt_classify_store_chk.sv
module pkt_classify_store_chk #(
  parameter int DATA_BANKS = 4,
  parameter int CNT_W      = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  pm_we,
  input logic                  dm_we,
  input logic                  wr_grant,
  input logic                  pass_valid,
  input logic [CNT_W-1:0]      drop_cnt,
  input logic [DATA_BANKS-1:0] data_full,
  input logic [DATA_BANKS-1:0] data_free
);

  // R1/R2: one packet class per cycle, never both memories
  assert_one_memory_R1: assert property (@(posedge clk) disable iff (rst)
    !(pm_we && dm_we));

  // R9: every data write lies inside the grant window
  assert_grant_covers_R9: assert property (@(posedge clk) disable iff (rst)
    dm_we |-> wr_grant);

  // R3: pass-through words never coincide with stores
  assert_pass_no_store_R3: assert property (@(posedge clk) disable iff (rst)
    pass_valid |-> (!pm_we && !dm_we && !wr_grant));

  // R6: drop count only moves upward
  assert_drop_monotone_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (drop_cnt >= $past(drop_cnt)));

  // R7: a full flag clears only after a release pulse
  assert_flag_release_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~data_full & $past(data_full) & ~$past(data_free)) == '0));

endmodule

bind pkt_classify_store pkt_classify_store_chk #(
  .DATA_BANKS(DATA_BANKS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .pm_we(pm_we), .dm_we(dm_we), .wr_grant(wr_grant),
  .pass_valid(pass_valid), .drop_cnt(drop_cnt), .data_full(data_full),
  .data_free(data_free)
);

// File: tb/test_pkt_classify_store.sv
`timescale 1ns/1ps
module test_pkt_classify_store;
  localparam int H  = 3;
  localparam int PB = 2;
  localparam int PD = 16;
  localparam int DB = 4;
  localparam int DD = 16;

  // vector: {tag, length, kind, bank}; kind 0 prog, 1 data, 2 pass, 3 drop
  localparam int NV = 9;
  localparam logic [47:0] VEC [NV] = '{
    {32'h0000_0001, 8'd8,  4'd1, 4'd0},
    {32'h0000_0000, 8'd7,  4'd0, 4'd0},
    {32'h0000_0005, 8'd6,  4'd2, 4'd0},
    {32'h0000_0001, 8'd5,  4'd1, 4'd1},
    {32'h0000_0000, 8'd6,  4'd0, 4'd1},
    {32'h0000_0000, 8'd6,  4'd3, 4'd0},
    {32'h0000_0001, 8'd4,  4'd1, 4'd2},
    {32'h0000_0001, 8'd20, 4'd1, 4'd3},
    {32'h0000_0001, 8'd5,  4'd3, 4'd0}
  };

  logic          clk = 1'b0, rst = 1'b1;
  logic          in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [31:0]   in_data = '0;
  logic [PB-1:0] prog_free = '0;
  logic [DB-1:0] data_free = '0;
  logic          pm_we, dm_we, wr_grant, pass_valid, pass_sop, pass_eop;
  logic [4:0]    pm_addr;
  logic [5:0]    dm_addr;
  logic [31:0]   pm_wdata, dm_wdata, pass_data;
  logic [PB-1:0] prog_full;
  logic [DB-1:0] data_full;
  logic [7:0]    drop_cnt;

  pkt_classify_store #(
    .DW(32), .HDR_WORDS(H), .PROG_BANKS(PB), .PROG_DEPTH(PD),
    .DATA_BANKS(DB), .DATA_DEPTH(DD), .CNT_W(8)
  ) i_pkt_classify_store (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .prog_free(prog_free), .data_free(data_free),
    .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
    .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata), .wr_grant(wr_grant),
    .prog_full(prog_full), .data_full(data_full), .pass_valid(pass_valid),
    .pass_sop(pass_sop), .pass_eop(pass_eop), .pass_data(pass_data),
    .drop_cnt(drop_cnt)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // output monitor, sampled between edges
  logic [31:0] pm_sh [PB*PD];
  logic [31:0] dm_sh [DB*DD];
  logic [31:0] ps_log [64];
  logic        ps_sop [64];
  logic        ps_eop [64];
  int pm_n = 0, dm_n = 0, gr_n = 0, ps_n = 0, ps_sop_cyc = 0;

  always @(negedge clk) begin
    if (pm_we) begin pm_sh[pm_addr] = pm_wdata; pm_n++; end
    if (dm_we) begin dm_sh[dm_addr] = dm_wdata; dm_n++; end
    if (wr_grant) gr_n++;
    if (pass_valid) begin
      ps_log[ps_n % 64] = pass_data;
      ps_sop[ps_n % 64] = pass_sop;
      ps_eop[ps_n % 64] = pass_eop;
      if (pass_sop) ps_sop_cyc = cyc;
      ps_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wrd(input int vid, input int i, input logic [31:0] tag);
    return (i == H) ? tag : {8'(vid), 8'(i), 16'hC3C3};
  endfunction

  logic [PB-1:0] exp_pfull = '0;
  logic [DB-1:0] exp_dfull = '0;
  int exp_drop = 0, sop_cyc = 0;

  task automatic send(input int vid, input logic [31:0] tag, input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = (i == 0); in_eop = (i == len - 1);
      in_data  = wrd(vid, i, tag);
      if (i == 0) sop_cyc = cyc + 1;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    repeat (H + 4) @(negedge clk);
    #1;
  endtask

  task automatic run_vec(input int vid, input logic [31:0] tag, input int len,
                         input int kind, input int bank);
    int pm0, dm0, gr0, ps0, n, bad;
    pm0 = pm_n; dm0 = dm_n; gr0 = gr_n; ps0 = ps_n;
    send(vid, tag, len);
    bad = 0;
    case (kind)
      0: begin // R1 program path, R8 payload limit
        n = (len - H - 1 > PD) ? PD : len - H - 1;
        chk(pm_n - pm0 == n, (len - H - 1 > PD) ? "R8 prog truncation" : "R1 prog write count", pm_n - pm0, n);
        for (int k = 0; k < n; k++) if (pm_sh[bank*PD + k] !== wrd(vid, H + 1 + k, tag)) bad++;
        chk(bad == 0, "R1 prog contents without tag", bad, 0);
        chk(dm_n == dm0, "R1 no data write", dm_n - dm0, 0);
        exp_pfull[bank] = 1'b1;
      end
      1: begin // R2 data path, R8 depth limit
        n = (len > DD) ? DD : len;
        chk(dm_n - dm0 == n, (len > DD) ? "R8 data truncation" : "R2 data write count", dm_n - dm0, n);
        for (int k = 0; k < n; k++) if (dm_sh[bank*DD + k] !== wrd(vid, k, tag)) bad++;
        chk(bad == 0, "R2 data stored whole", bad, 0);
        chk(pm_n == pm0, "R2 no prog write", pm_n - pm0, 0);
        exp_dfull[bank] = 1'b1;
      end
      2: begin // R3 pass-through, R4 latency
        chk(ps_n - ps0 == len, "R3 pass word count", ps_n - ps0, len);
        for (int k = 0; k < len; k++) begin
          if (ps_log[(ps0 + k) % 64] !== wrd(vid, k, tag)) bad++;
          if (ps_sop[(ps0 + k) % 64] !== (k == 0)) bad++;
          if (ps_eop[(ps0 + k) % 64] !== (k == len - 1)) bad++;
        end
        chk(bad == 0, "R3 pass contents and framing", bad, 0);
        chk(pm_n == pm0 && dm_n == dm0, "R3 nothing stored", pm_n - pm0 + dm_n - dm0, 0);
        chk(ps_sop_cyc - sop_cyc == H + 1, "R4 fixed latency", ps_sop_cyc - sop_cyc, H + 1);
      end
      default: begin // R6 drop
        chk(pm_n == pm0 && dm_n == dm0, "R6 dropped packet not written", pm_n - pm0 + dm_n - dm0, 0);
        exp_drop++;
      end
    endcase
    chk(gr_n - gr0 == ((kind == 1) ? len : 0), "R9 grant cycle count", gr_n - gr0, (kind == 1) ? len : 0);
    chk(drop_cnt == 8'(exp_drop), "R6 drop counter", drop_cnt, exp_drop);
    chk(data_full == exp_dfull, "R5 data full flags", data_full, exp_dfull);
    chk(prog_full == exp_pfull, "R5 prog full flags", prog_full, exp_pfull);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    for (int i = 0; i < PB*PD; i++) pm_sh[i] = '0;
    for (int i = 0; i < DB*DD; i++) dm_sh[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R10 reset state
    chk(prog_full == '0 && data_full == '0, "R10 flags after reset", {prog_full, data_full}, 0);
    chk(drop_cnt == 0, "R10 drop count after reset", drop_cnt, 0);
    chk(!pm_we && !dm_we && !wr_grant && !pass_valid, "R10 outputs idle",
        {pm_we, dm_we, wr_grant, pass_valid}, 0);

    for (int v = 0; v < NV; v++)
      run_vec(v, VEC[v][47:16], int'(VEC[v][15:8]), int'(VEC[v][7:4]), int'(VEC[v][3:0]));

    // R7 release a data bank; the pointer has wrapped to bank 0
    @(negedge clk); data_free = 4'b0001;
    @(negedge clk); data_free = '0; #1;
    exp_dfull[0] = 1'b0;
    chk(data_full == exp_dfull, "R7 data release clears flag", data_full, exp_dfull);
    run_vec(9, 32'h1, 6, 1, 0);

    // R7 program release, then R8 oversize program into bank 1
    @(negedge clk); prog_free = 2'b01;
    @(negedge clk); prog_free = '0; #1;
    exp_pfull[0] = 1'b0;
    chk(prog_full == exp_pfull, "R7 prog release clears flag", prog_full, exp_pfull);
    run_vec(10, 32'h0, 9, 0, 0);
    @(negedge clk); prog_free = 2'b10;
    @(negedge clk); prog_free = '0; #1;
    exp_pfull[1] = 1'b0;
    run_vec(11, 32'h0, H + 1 + PD + 4, 0, 1);

    // R10 reset mid-run restarts pointers, flags and counter
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0; #1;
    exp_dfull = '0; exp_pfull = '0; exp_drop = 0;
    chk(prog_full == '0 && data_full == '0 && drop_cnt == 0, "R10 mid-run reset",
        {prog_full, data_full, drop_cnt}, 0);
    run_vec(12, 32'h1, 5, 1, 0);
    run_vec(13, 32'h0, 6, 0, 0);
    run_vec(14, 32'hFFFF_FFFF, 5, 2, 0);

    summary();
  end

endmodule